// File: doc/BRIEF.md
# Conversion Rate and Filter Settling Sequencer

This block produces the timing of conversion results for an oversampling converter's decimation filter. A range bit and a two-bit rate select together form a three-bit rate code. That code picks the number of reference ticks between results. Time is measured only in strobes on a prescaled `tick` input. The block takes no account of the fast system clock.

A filter synchronisation control, `filt_sync`, holds the settling logic in its restart state while it is high. After it falls, the block waits three full update periods for the filter to settle and then announces the first result. After that, a result follows every single update period. The active-low ready flag behaves as follows:
- It drops whenever a result is loaded.
- It rises when the consumer reports the result as read out, or one tick before the next load.
- Synchronisation never raises it.

A change of rate code restarts the settling count in the same way a sync release does.

Top module: `rate_settle_seq`

## Requirements
- R1: With `hi_range`=0, rate_sel 00/01/10/11 (20, 25, 100, 200 results/s) give update periods of 50, 40, 10 and 5 ticks at the default TICK_HZ=1000. Each period is TICK_HZ/rate, rounded to nearest, and never below 2.
- R2: With `hi_range`=1, rate_sel 00/01/10/11 (50, 60, 250, 500 results/s) give update periods of 20, 17, 4 and 2 ticks at TICK_HZ=1000.
- R3: While `filt_sync` is high, no `new_result` pulse is produced and `settling` reads 1, whatever ticks arrive.
- R4: After `filt_sync` falls, the first `new_result` pulse follows the 3×P-th tick taken with sync low, where P is the selected period. `settling` reads 0 from that pulse on.
- R5: After the first result, each further `new_result` pulse follows every P-th tick while sync stays low. Each pulse lasts exactly one clock.
- R6: `ready_n` is 0 in the cycle `new_result` pulses.
- R7: A `read_done` pulse in a cycle without a tick sets `ready_n` to 1 in the next cycle.
- R8: If unread, `ready_n` returns to 1 after the tick that comes one tick before the next load, and it drops again at that load.
- R9: Asserting or holding `filt_sync` never changes `ready_n`. A low `ready_n` stays low until it is read.
- R10: A change of the three-bit rate code while sync is low restarts settling. The next result follows 3×P_new ticks.
- R11: During and after reset, `ready_n`=1, `new_result`=0 and `settling`=1.
- R12: Results advance only on ticks. Without tick strobes, no `new_result` pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle strobe of the prescaled reference |
| hi_range | input | 1 | Rate range select, MSB of the rate code |
| rate_sel | input | 2 | Rate select, low two bits of the rate code |
| filt_sync | input | 1 | High holds filter and calibration timing in restart |
| read_done | input | 1 | Pulse: current result fully read out |
| ready_n | output | 1 | Active-low result-ready flag |
| new_result | output | 1 | One-cycle pulse when a result is loaded |
| settling | output | 1 | High from restart until the first settled result |

## Verification
The properties take for granted that `tick` is a strobe that is never high in two consecutive cycles. The single-pulse and read-clearing checks depend on that spacing. They also assume `read_done` is a pulse that the consumer drives only as a report of a finished readout. The stimulus always raises `tick` for exactly one cycle, followed by idle cycles. It drives `read_done` only in cycles without a tick, and it changes the rate code only at clock midpoints.

// File: rtl/rate_seq_pkg.sv
// Package: shared types and rate arithmetic for the rate/settling sequencer.
// Assumes the tick rate is an integer in ticks per second.
package rate_seq_pkg;

    // Three-bit rate code: {hi_range, rate_sel[1:0]}
    typedef logic [2:0] rate_code_t;

    // Number of update periods the filter needs to settle after a restart
    localparam int unsigned SETTLE_PERIODS = 3;

    // Smallest period allowed so that the pre-load tick differs from the load tick
    localparam int unsigned MIN_PERIOD = 2;

    // Results per second selected by a rate code (non-monotonic in the code)
    function automatic int unsigned rate_hz(input rate_code_t code);
        int unsigned hz;
        case (code)
            3'b000:  hz = 20;
            3'b001:  hz = 25;
            3'b010:  hz = 100;
            3'b011:  hz = 200;
            3'b100:  hz = 50;
            3'b101:  hz = 60;
            3'b110:  hz = 250;
            default: hz = 500;
        endcase
        return hz;
    endfunction

    // Ticks per update period, rounded to nearest and clamped at MIN_PERIOD
    function automatic int unsigned period_ticks(input int unsigned tick_hz,
                                                 input rate_code_t code);
        int unsigned hz;
        int unsigned p;
        hz = rate_hz(code);
        p  = (tick_hz + hz / 2) / hz;
        if (p < MIN_PERIOD) p = MIN_PERIOD;
        return p;
    endfunction

    // Largest period over all codes, used to size the counters
    function automatic int unsigned max_period(input int unsigned tick_hz);
        int unsigned m;
        m = MIN_PERIOD;
        for (int i = 0; i < 8; i++) begin
            if (period_ticks(tick_hz, rate_code_t'(i)) > m)
                m = period_ticks(tick_hz, rate_code_t'(i));
        end
        return m;
    endfunction

endpackage

// File: rtl/rseq_period_lut.sv
// Module: rseq_period_lut
// Maps a rate code to its update period and its settling time, in ticks.
// Assumes CNT_W is wide enough for SETTLE_PERIODS times the largest period.
module rseq_period_lut
    import rate_seq_pkg::*;
#(
    parameter int unsigned TICK_HZ = 1000,
    parameter int unsigned CNT_W   = 8
) (
    input  rate_code_t       code,
    output logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] settle
);

    localparam int unsigned N_CODES = 8;

    logic [CNT_W-1:0] per_tbl [N_CODES];
    logic [CNT_W-1:0] set_tbl [N_CODES];

    // One table entry per code, each a constant computed at elaboration
    for (genvar g = 0; g < N_CODES; g++) begin : g_entry
        localparam int unsigned P = period_ticks(TICK_HZ, rate_code_t'(g));
        assign per_tbl[g] = CNT_W'(P);
        assign set_tbl[g] = CNT_W'(SETTLE_PERIODS * P);
    end

    // Select the entry for the live code
    always_comb begin
        period = per_tbl[code];
        settle = set_tbl[code];
    end

endmodule

// File: rtl/rseq_update_timer.sv
// Module: rseq_update_timer
// Down-counts ticks to the next result load. A restart reloads the full
// settling time; afterwards each load reloads one period.
// Assumes tick is a one-cycle strobe and period is at least 2.
module rseq_update_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] settle,
    output logic             load_evt,
    output logic             pre_evt
);

    logic [CNT_W-1:0] remain;
    logic             last_tick;
    logic             pre_tick;

    // Decode the counter position of the current tick
    always_comb begin
        last_tick = (remain <= CNT_W'(1));
        pre_tick  = (remain == CNT_W'(2));
        load_evt  = tick && !restart && last_tick;
        pre_evt   = tick && !restart && pre_tick;
    end

    // Remaining-tick counter: reload on restart, count down on ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= settle;
        end else if (restart) begin
            remain <= settle;
        end else if (tick) begin
            if (last_tick) remain <= period;
            else           remain <= remain - CNT_W'(1);
        end
    end

endmodule

// File: rtl/rseq_ready_flag.sv
// Module: rseq_ready_flag
// Holds the active-low ready flag, the result strobe and the settling flag.
// Assumes load_evt and pre_evt are never high together (period >= 2).
module rseq_ready_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic load_evt,
    input  logic pre_evt,
    input  logic read_done,
    output logic ready_n,
    output logic new_result,
    output logic settling
);

    // Result strobe: registered copy of the load event
    always_ff @(posedge clk) begin
        if (!rst_n) new_result <= 1'b0;
        else        new_result <= load_evt;
    end

    // Ready flag: a load drops it, a readout or the pre-load tick raises it
    always_ff @(posedge clk) begin
        if (!rst_n)                      ready_n <= 1'b1;
        else if (load_evt)               ready_n <= 1'b0;
        else if (pre_evt || read_done)   ready_n <= 1'b1;
    end

    // Settling flag: set by any restart, cleared by the first load after it
    always_ff @(posedge clk) begin
        if (!rst_n)        settling <= 1'b1;
        else if (restart)  settling <= 1'b1;
        else if (load_evt) settling <= 1'b0;
    end

endmodule

// File: rtl/rate_settle_seq.sv
// Module: rate_settle_seq (top)
// Sequences conversion-result timing. Detects a sync hold or a rate-code
// change as a restart, looks up the period, counts ticks and drives the
// ready flag. Assumes tick is a strobe no more often than every other clock.
module rate_settle_seq
    import rate_seq_pkg::*;
#(
    parameter int unsigned TICK_HZ = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       hi_range,
    input  logic [1:0] rate_sel,
    input  logic       filt_sync,
    input  logic       read_done,
    output logic       ready_n,
    output logic       new_result,
    output logic       settling
);

    localparam int unsigned PER_MAX    = max_period(TICK_HZ);
    localparam int unsigned SETTLE_MAX = SETTLE_PERIODS * PER_MAX;
    localparam int unsigned CNT_W      = $clog2(SETTLE_MAX + 1);

    rate_code_t       code_now;
    rate_code_t       code_q;
    logic             code_chg;
    logic             restart;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] settle;
    logic             load_evt;
    logic             pre_evt;

    // Form the rate code and decide whether this cycle restarts settling
    always_comb begin
        code_now = {hi_range, rate_sel};
        code_chg = (code_now != code_q);
        restart  = filt_sync || code_chg;
    end

    // Remember the code seen in the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= code_now;
        else        code_q <= code_now;
    end

    rseq_period_lut #(
        .TICK_HZ (TICK_HZ),
        .CNT_W   (CNT_W)
    ) u_lut (
        .code    (code_now),
        .period  (period),
        .settle  (settle)
    );

    rseq_update_timer #(
        .CNT_W    (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .restart  (restart),
        .period   (period),
        .settle   (settle),
        .load_evt (load_evt),
        .pre_evt  (pre_evt)
    );

    rseq_ready_flag u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .load_evt   (load_evt),
        .pre_evt    (pre_evt),
        .read_done  (read_done),
        .ready_n    (ready_n),
        .new_result (new_result),
        .settling   (settling)
    );

endmodule

// File: rtl/rseq_checker.sv
// Module: rseq_checker
// Port-level properties of rate_settle_seq, attached with bind.
// Assumes tick is never high in two consecutive cycles.
module rseq_checker (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic filt_sync,
    input logic read_done,
    input logic ready_n,
    input logic new_result,
    input logic settling
);

    AST_NO_LOAD_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        filt_sync |=> !new_result); // R3
    AST_SYNC_SETTLING: assert property (@(posedge clk) disable iff (!rst_n)
        filt_sync |=> settling); // R3
    AST_LOAD_ENDS_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        new_result |-> !settling); // R4
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        new_result |=> !new_result); // R5
    AST_LOAD_READY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        new_result |-> !ready_n); // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (read_done && !tick) |=> ready_n); // R7
    AST_SYNC_KEEPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_sync && !read_done) |=> $stable(ready_n)); // R9
    AST_LOAD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        new_result |-> $past(tick)); // R12

endmodule

bind rate_settle_seq rseq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .filt_sync  (filt_sync),
    .read_done  (read_done),
    .ready_n    (ready_n),
    .new_result (new_result),
    .settling   (settling)
);

// File: tb/test_rate_settle_seq.sv
module test_rate_settle_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       hi_range = 1'b0;
    logic [1:0] rate_sel = 2'b00;
    logic       filt_sync = 1'b0;
    logic       read_done = 1'b0;
    logic       ready_n;
    logic       new_result;
    logic       settling;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    bit got_load;

    // Stimulus table: rate code and expected period in ticks (TICK_HZ=1000)
    localparam int VEC_N = 8;
    localparam int VEC_CODE [VEC_N] = '{0, 1, 2, 3, 4, 5, 6, 7};
    localparam int VEC_PER  [VEC_N] = '{50, 40, 10, 5, 20, 17, 4, 2};

    always #2.5 clk = ~clk;

    rate_settle_seq i_rate_settle_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .hi_range   (hi_range),
        .rate_sel   (rate_sel),
        .filt_sync  (filt_sync),
        .read_done  (read_done),
        .ready_n    (ready_n),
        .new_result (new_result),
        .settling   (settling)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One tick strobe; got_load records the result pulse right after it
    task automatic tick_pulse();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        got_load = new_result;
        repeat (2) @(negedge clk);
    endtask

    // Ticks until a result pulse appears; returns the tick count
    task automatic count_to_load(output int n);
        n = 0;
        got_load = 1'b0;
        while (!got_load && n < 400) begin
            tick_pulse();
            n++;
        end
    endtask

    task automatic read_out();
        @(negedge clk) read_done = 1'b1;
        @(negedge clk) read_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        int seen;
        // R11: reset state
        repeat (4) @(negedge clk);
        check("R11 ready_n", int'(ready_n), 1);
        check("R11 new_result", int'(new_result), 0);
        check("R11 settling", int'(settling), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 ready_n after release", int'(ready_n), 1);

        // Table walk: settling 3P, then steady period P, per rate code
        for (int v = 0; v < VEC_N; v++) begin
            filt_sync = 1'b1;
            {hi_range, rate_sel} = 3'(VEC_CODE[v]);
            repeat (3) @(negedge clk);
            tick_pulse();
            check("R3 no load under sync", int'(got_load), 0);
            check("R3 settling under sync", int'(settling), 1);
            filt_sync = 1'b0;
            count_to_load(n);
            check(VEC_CODE[v] < 4 ? "R1 R4 settle ticks" : "R2 R4 settle ticks",
                  n, 3 * VEC_PER[v]);
            check("R6 ready_n at load", int'(ready_n), 0);
            check("R4 settling cleared", int'(settling), 0);
            count_to_load(n);
            check(VEC_CODE[v] < 4 ? "R1 R5 period ticks" : "R2 R5 period ticks",
                  n, VEC_PER[v]);
            read_out();
            check("R7 read raises ready_n", int'(ready_n), 1);
        end

        // R8: unread result, ready_n rises one tick before the next load
        filt_sync = 1'b1;
        {hi_range, rate_sel} = 3'b011;
        repeat (3) @(negedge clk);
        filt_sync = 1'b0;
        count_to_load(n);
        check("R4 settle P=5", n, 15);
        repeat (3) tick_pulse();
        check("R8 still low before pre tick", int'(ready_n), 0);
        tick_pulse();
        check("R8 high after pre tick", int'(ready_n), 1);
        tick_pulse();
        check("R8 load after pre tick", int'(got_load), 1);
        check("R8 low again at load", int'(ready_n), 0);

        // R9: sync keeps a low ready_n low
        filt_sync = 1'b1;
        seen = 0;
        for (int k = 0; k < 6; k++) begin
            tick_pulse();
            if (got_load) seen++;
        end
        check("R9 ready_n held under sync", int'(ready_n), 0);
        check("R3 no loads under long sync", seen, 0);
        filt_sync = 1'b0;
        count_to_load(n);
        check("R4 settle after long sync", n, 15);

        // R10: code change without sync restarts settling with the new period
        @(negedge clk) rate_sel = 2'b10;
        count_to_load(n);
        check("R10 restart on code change", n, 30);

        // R12: no ticks, no results
        seen = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (new_result) seen++;
        end
        check("R12 no result without ticks", seen, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule